// File: doc/BRIEF.md
# Table-Driven Shared Memory Slot Arbiter

The arbiter decides, every clock cycle, which of sixteen processor cores may use a single shared memory port. Rather than stepping through the cores in a hard-wired order, it steps through a circular schedule table. Each table entry names the core that owns that slot. A core listed in several entries gets more bandwidth and a shorter wait. A core listed nowhere gets no scheduled slot at all. The number of entries that take part in the rotation can be programmed, so a short schedule reduces the worst-case latency for the cores it lists.

When the owner of the current slot is not asking for memory, the slot can be handed to another requesting core, but only to a core whose borrowing permission is switched on. If several permitted cores are waiting, a rotating priority pointer picks the winner. The owner always beats any borrower, and cores without permission are only ever granted in their own slots, so their timing stays fixed. Each grant moves one 128-bit transfer (four 32-bit words) from the granted core to the memory port. A configuration port loads the schedule, its length and the permission mask. After a lock bit is set, all further configuration writes are refused and reported.

Top module: `slot_arbiter`

## Requirements
- R1: After reset the schedule entry i holds core i for every i, the active length is 16 and no core may borrow, so with every core requesting the grants step through cores 0 to 15 in turn and start at core 0 in the first cycle after reset.
- R2: The slot pointer advances by one entry on every clock edge, used or not, and returns to entry 0 after entry (length-1); a programmed length of 0 means 16.
- R3: A configuration write to address 0..15 stores cfg_wdata[3:0] as the core number of that schedule entry; address 16 stores cfg_wdata[3:0] as the active length. A core may fill several entries, and a core in no active entry is never granted while its borrow bit is clear.
- R4: Whenever the owner of the current entry requests, that owner is granted, whatever other cores request.
- R5: Address 17 stores cfg_wdata[15:0] as the borrow mask (bit i for core i). When the owner is idle, a requesting core whose mask bit is set may take the slot; a core whose bit is clear is never granted outside its own entries.
- R6: Among competing borrowers the search starts at a rotating pointer (0 after reset) and takes the first requester in ascending core order with wrap; after a borrow the pointer moves to the core after the winner.
- R7: At most one core_grant bit is set in any cycle, and only for a core whose request is set in that same cycle; grants respond to requests combinationally.
- R8: mem_en is high exactly when a grant is given; mem_core then carries the granted core's number and mem_wdata carries that core's 128-bit slice core_wdata[128*i +: 128].
- R9: A write to address 18 with cfg_wdata[0]=1 sets the lock; while locked every configuration write leaves schedule, length and mask unchanged, and cfg_reject is high in the cycle after each such write and low otherwise.
- R10: The lock can only be cleared by reset; writing 0 to address 18 while locked is itself rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 16 | Per-core memory request |
| core_grant | output | 16 | Per-core grant, one-hot or zero |
| core_wdata | input | 2048 | 128-bit transfer word of each core, core i at bits 128*i upward |
| mem_en | output | 1 | Shared memory access this cycle |
| mem_core | output | 4 | Number of the granted core |
| mem_wdata | output | 128 | Transfer word of the granted core |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address: 0..15 entries, 16 length, 17 borrow mask, 18 lock |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_reject | output | 1 | Pulses the cycle after a write refused by the lock |

## Verification
The hardest case to reach from the ports is a borrowed slot whose outcome depends on the rotating pointer, because it needs a known slot phase, a non-default schedule, the mask set and an idle owner at once. The bench keeps its own count of the slot position from reset and from the lengths it writes, programs a three-entry schedule where the listed owners stay silent, and then issues requests from two permitted non-owners across consecutive slots so the pointer hand-off shows in the grant order. The same phase tracking lets it confirm after locking that refused writes left the schedule and length as they were.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    localparam int NCORE   = 16;
    localparam int CORE_W  = $clog2(NCORE);
    localparam int TAB_D   = 16;
    localparam int TAB_AW  = $clog2(TAB_D);
    localparam int WORD_W  = 32;
    localparam int WORDS   = 4;
    localparam int XFER_W  = WORD_W * WORDS;
    localparam int CFG_AW  = 5;
    localparam int CFG_DW  = NCORE;

    localparam logic [CFG_AW-1:0] ADDR_LEN   = CFG_AW'(TAB_D);
    localparam logic [CFG_AW-1:0] ADDR_MOOCH = CFG_AW'(TAB_D + 1);
    localparam logic [CFG_AW-1:0] ADDR_LOCK  = CFG_AW'(TAB_D + 2);

    typedef enum logic [2:0] {
        CFG_ENTRY,
        CFG_LEN,
        CFG_MOOCH,
        CFG_LOCK,
        CFG_NONE
    } cfg_kind_e;

    typedef logic [CORE_W-1:0] core_id_t;

    typedef struct packed {
        logic     valid;
        logic     borrowed;
        core_id_t core;
    } grant_t;

    function automatic cfg_kind_e decode_addr(input logic [CFG_AW-1:0] a);
        if (int'(a) < TAB_D) return CFG_ENTRY;
        if (a == ADDR_LEN)   return CFG_LEN;
        if (a == ADDR_MOOCH) return CFG_MOOCH;
        if (a == ADDR_LOCK)  return CFG_LOCK;
        return CFG_NONE;
    endfunction

endpackage

// File: rtl/slot_arb_cfg.sv
module slot_arb_cfg
    import slot_arb_pkg::*;
#(
    parameter int N  = NCORE,
    parameter int CW = CORE_W,
    parameter int D  = TAB_D,
    parameter int AW = TAB_AW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    output logic [D-1:0][CW-1:0]  tab,
    output logic [AW:0]           len_eff,
    output logic [N-1:0]          mooch_en,
    output logic                  locked,
    output logic                  cfg_reject
);
    cfg_kind_e        kind;
    logic [AW-1:0]    len_q;
    logic             accept;

    assign kind   = decode_addr(cfg_addr);
    assign accept = cfg_we && !locked;

    for (genvar i = 0; i < D; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                tab[i] <= CW'(i % N);
            else if (accept && kind == CFG_ENTRY && int'(cfg_addr) == i)
                tab[i] <= cfg_wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= '0;
            mooch_en   <= '0;
            locked     <= 1'b0;
            cfg_reject <= 1'b0;
        end else begin
            cfg_reject <= cfg_we && locked;
            if (accept) begin
                case (kind)
                    CFG_LEN:   len_q    <= cfg_wdata[AW-1:0];
                    CFG_MOOCH: mooch_en <= cfg_wdata[N-1:0];
                    CFG_LOCK:  locked   <= cfg_wdata[0];
                    default:   ;
                endcase
            end
        end
    end

    assign len_eff = (len_q == '0) ? (AW+1)'(D) : {1'b0, len_q};

endmodule

// File: rtl/slot_arb_seq.sv
module slot_arb_seq
    import slot_arb_pkg::*;
#(
    parameter int AW = TAB_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW:0]   len_eff,
    output logic [AW-1:0] ptr
);
    logic [AW:0] nxt;

    assign nxt = {1'b0, ptr} + (AW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (nxt == len_eff)
            ptr <= '0;
        else
            ptr <= nxt[AW-1:0];
    end

endmodule

// File: rtl/slot_arb_pick.sv
module slot_arb_pick
    import slot_arb_pkg::*;
#(
    parameter int N  = NCORE,
    parameter int CW = CORE_W
) (
    input  logic [N-1:0]  cand,
    input  logic [CW-1:0] start,
    output logic          found,
    output logic [CW-1:0] winner
);
    always_comb begin
        int idx;
        found  = 1'b0;
        winner = '0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(start) + k) % N;
            if (!found && cand[idx]) begin
                found  = 1'b1;
                winner = CW'(idx);
            end
        end
    end

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import slot_arb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCORE-1:0]        core_req,
    output logic [NCORE-1:0]        core_grant,
    input  logic [NCORE*XFER_W-1:0] core_wdata,
    output logic                    mem_en,
    output logic [CORE_W-1:0]       mem_core,
    output logic [XFER_W-1:0]       mem_wdata,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [CFG_DW-1:0]       cfg_wdata,
    output logic                    cfg_reject
);
    logic [TAB_D-1:0][CORE_W-1:0] tab;
    logic [TAB_AW:0]              len_eff;
    logic [NCORE-1:0]             mooch_en;
    logic                         locked;
    logic [TAB_AW-1:0]            ptr;
    core_id_t                     owner;
    core_id_t                     rr_q;
    core_id_t                     winner;
    logic                         found;
    grant_t                       gnt;

    slot_arb_cfg #(.N(NCORE), .CW(CORE_W), .D(TAB_D), .AW(TAB_AW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .tab        (tab),
        .len_eff    (len_eff),
        .mooch_en   (mooch_en),
        .locked     (locked),
        .cfg_reject (cfg_reject)
    );

    slot_arb_seq #(.AW(TAB_AW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .len_eff (len_eff),
        .ptr     (ptr)
    );

    slot_arb_pick #(.N(NCORE), .CW(CORE_W)) u_pick (
        .cand   (core_req & mooch_en),
        .start  (rr_q),
        .found  (found),
        .winner (winner)
    );

    assign owner = tab[ptr];

    always_comb begin
        gnt = '0;
        if (core_req[owner]) begin
            gnt.valid = 1'b1;
            gnt.core  = owner;
        end else if (found) begin
            gnt.valid    = 1'b1;
            gnt.borrowed = 1'b1;
            gnt.core     = winner;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (gnt.valid && gnt.borrowed)
            rr_q <= (int'(gnt.core) == NCORE - 1) ? '0 : gnt.core + CORE_W'(1);
    end

    assign core_grant = gnt.valid ? (NCORE'(1) << gnt.core) : '0;
    assign mem_en     = gnt.valid;
    assign mem_core   = gnt.core;
    assign mem_wdata  = gnt.valid ? core_wdata[gnt.core*XFER_W +: XFER_W] : '0;

endmodule

// File: rtl/slot_arb_chk.sv
module slot_arb_chk
    import slot_arb_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [NCORE-1:0]             core_req,
    input logic [NCORE-1:0]             core_grant,
    input logic                         cfg_we,
    input logic                         cfg_reject,
    input logic [TAB_D-1:0][CORE_W-1:0] tab,
    input logic [TAB_AW:0]              len_eff,
    input logic [NCORE-1:0]             mooch_en,
    input logic                         locked,
    input logic [TAB_AW-1:0]            ptr
);
    logic [CORE_W-1:0] own;
    assign own = tab[ptr];

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_grant)); // R7

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (core_grant & ~core_req) == '0); // R7

    AST_OWNER_WINS: assert property (@(posedge clk) disable iff (rst)
        core_req[own] |-> core_grant[own]); // R4

    AST_NO_FOREIGN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (core_grant & ~mooch_en & ~(NCORE'(1) << own)) == '0); // R5

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ptr} == len_eff - (TAB_AW+1)'(1)) |=> (ptr == '0)); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ptr} != len_eff - (TAB_AW+1)'(1)) |=> (ptr == TAB_AW'($past(ptr) + 1'b1))); // R2

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(tab) && $stable(mooch_en) && $stable(len_eff))); // R9

    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (locked && cfg_we) |=> cfg_reject); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R10

endmodule

bind slot_arbiter slot_arb_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_req   (core_req),
    .core_grant (core_grant),
    .cfg_we     (cfg_we),
    .cfg_reject (cfg_reject),
    .tab        (tab),
    .len_eff    (len_eff),
    .mooch_en   (mooch_en),
    .locked     (locked),
    .ptr        (ptr)
);

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb;
    import slot_arb_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NCORE-1:0]        core_req = '0;
    logic [NCORE-1:0]        core_grant;
    logic [NCORE*XFER_W-1:0] core_wdata;
    logic                    mem_en;
    logic [CORE_W-1:0]       mem_core;
    logic [XFER_W-1:0]       mem_wdata;
    logic                    cfg_we = 1'b0;
    logic [CFG_AW-1:0]       cfg_addr = '0;
    logic [CFG_DW-1:0]       cfg_wdata = '0;
    logic                    cfg_reject;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int bptr = 0;
    int blen = 16;

    always #2 clk = ~clk;

    slot_arbiter u_dut (
        .clk        (clk),
        .rst        (rst),
        .core_req   (core_req),
        .core_grant (core_grant),
        .core_wdata (core_wdata),
        .mem_en     (mem_en),
        .mem_core   (mem_core),
        .mem_wdata  (mem_wdata),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_reject (cfg_reject)
    );

    // slot phase tracker from R2: one step per edge, wrap at blen or at 16
    always @(posedge clk) begin
        if (rst) bptr <= 0;
        else if (bptr + 1 == blen || bptr + 1 == 16) bptr <= 0;
        else bptr <= bptr + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [XFER_W-1:0] word_of(input int i);
        return {32'(i), 32'hA5A5_0000 | 32'(i), 32'(i * 3 + 7), 32'hFEED_0000 | 32'(i)};
    endfunction

    initial begin
        for (int i = 0; i < NCORE; i++)
            core_wdata[i*XFER_W +: XFER_W] = word_of(i);
    end

    task automatic check(input string tag, input logic [XFER_W-1:0] act, input logic [XFER_W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive a request at a negedge, sample the combinational grant, move on
    task automatic slot(input string tag, input logic [NCORE-1:0] r, input logic [NCORE-1:0] exp);
        int idx;
        core_req = r;
        #1;
        check(tag, XFER_W'(core_grant), XFER_W'(exp));
        check({tag, " mem_en"}, XFER_W'(mem_en), XFER_W'(exp != '0));
        if (exp != '0) begin
            idx = 0;
            for (int i = 0; i < NCORE; i++) if (exp[i]) idx = i;
            check({tag, " mem_core"}, XFER_W'(mem_core), XFER_W'(idx));
            check({tag, " mem_wdata"}, mem_wdata, word_of(idx));
        end
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [CFG_AW-1:0] a, input logic [CFG_DW-1:0] d);
        core_req  = '0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ptr(input int n);
        core_req = '0;
        while (bptr != n) @(negedge clk);
    endtask

    // {request, expected grant} for entries 0..15 then 0 again, default schedule
    localparam logic [31:0] VEC [17] = '{
        {16'hFFFF, 16'h0001}, {16'h0001, 16'h0000}, {16'h0004, 16'h0004},
        {16'h0000, 16'h0000}, {16'hFFFF, 16'h0010}, {16'h0021, 16'h0020},
        {16'h0080, 16'h0000}, {16'h0080, 16'h0080}, {16'hFF00, 16'h0100},
        {16'h0000, 16'h0000}, {16'h0400, 16'h0400}, {16'hF7FF, 16'h0000},
        {16'h1000, 16'h1000}, {16'hFFFF, 16'h2000}, {16'h4000, 16'h4000},
        {16'h8001, 16'h8000}, {16'h0001, 16'h0001}
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 grant idle in reset", XFER_W'(core_grant), '0);
        check("R9 reject low in reset", XFER_W'(cfg_reject), '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R4 R5 R7 R8: default rotation and wrap at 16
        for (int v = 0; v < 17; v++)
            slot($sformatf("R1 vec%0d", v), VEC[v][31:16], VEC[v][15:0]);

        // R2 R3: length 3, entries 5,5,7
        cfg_write(ADDR_LEN, 16'd3);
        check("R9 accepted write no reject", XFER_W'(cfg_reject), '0);
        blen = 3;
        cfg_write(5'd0, 16'd5);
        cfg_write(5'd1, 16'd5);
        cfg_write(5'd2, 16'd7);
        wait_ptr(0);
        slot("R3 dup entry0", 16'hFFFF, 16'h0020);
        slot("R3 dup entry1", 16'hFFFF, 16'h0020);
        slot("R3 entry2", 16'hFFFF, 16'h0080);
        slot("R2 wrap at 3", 16'hFFFF, 16'h0020);
        wait_ptr(0);
        slot("R3 unlisted core 0", 16'h0001, 16'h0000);
        slot("R3 unlisted core 0", 16'h0001, 16'h0000);
        slot("R3 unlisted core 0", 16'h0001, 16'h0000);

        // R5 R6: borrowing by cores 0..2
        cfg_write(ADDR_MOOCH, 16'h0007);
        wait_ptr(0);
        slot("R6 borrow first", 16'h0003, 16'h0001);
        slot("R6 borrow rotate", 16'h0003, 16'h0002);
        slot("R6 borrow wrap", 16'h0003, 16'h0001);
        slot("R4 owner beats borrower", 16'h0023, 16'h0020);
        slot("R5 no borrow bit", 16'h0008, 16'h0000);

        // R9 R10: lock
        cfg_write(ADDR_LOCK, 16'h0001);
        check("R9 lock write accepted", XFER_W'(cfg_reject), '0);
        cfg_write(5'd0, 16'd9);
        check("R9 reject flag", XFER_W'(cfg_reject), XFER_W'(1));
        @(negedge clk);
        check("R9 reject one cycle", XFER_W'(cfg_reject), '0);
        cfg_write(ADDR_LEN, 16'd0);
        check("R9 reject length", XFER_W'(cfg_reject), XFER_W'(1));
        cfg_write(ADDR_MOOCH, 16'h0000);
        wait_ptr(0);
        slot("R9 entry kept", 16'hFFFF, 16'h0020);
        wait_ptr(2);
        slot("R9 length kept", 16'h0000, 16'h0000);
        slot("R9 wrap still 3", 16'hFFFF, 16'h0020);
        slot("R9 mask kept", 16'h0004, 16'h0004);
        cfg_write(ADDR_LOCK, 16'h0000);
        check("R10 unlock rejected", XFER_W'(cfg_reject), XFER_W'(1));
        cfg_write(5'd0, 16'd2);
        check("R10 still locked", XFER_W'(cfg_reject), XFER_W'(1));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule